// File: doc/BRIEF.md
# Receive Descriptor and Status Ring Engine

This block is the receive half of a queue-based Ethernet DMA engine. Software keeps two rings in memory. The descriptor ring hands free buffers to the engine. The status ring takes back one two-word completion entry for each frame. Software grants room on each ring by writing a count to that ring's credit input. At start it writes the ring size, and after each service pass it writes the number of entries it has handled. The two credit counts are separate, and both rings wrap at a byte length that software programs.

A frame-end pulse from the MAC side gives the frame length and its error flags. The engine reads the second word of the current descriptor, which holds the buffer index and the buffer length. It then writes a status entry that echoes that index, advances both ring pointers, uses up one credit on each ring, and can pulse a receive interrupt. A frame that finds either ring without credit is dropped and counted, and nothing is written for it.

The controller has five states. IDLE waits for a frame. FETCH issues the descriptor read. WAIT captures the read data. STS0 writes status word 0, and STS1 writes status word 1. The transitions are as follows. IDLE goes to FETCH when a frame is accepted; otherwise it stays in IDLE and counts a drop if the frame was refused. FETCH always goes to WAIT, WAIT to STS0, STS0 to STS1, and STS1 back to IDLE. Memory reads return data one cycle after the request.

Top module: `rxq_engine`

## Requirements
- R1: After reset, frm_ready is 1, while mem_en, irq, rx_active and drop_count are all 0.
- R2: rx_active follows enable with a one-cycle delay. While enable is 0, a frame pulse causes no memory access and does not change drop_count.
- R3: One cycle after a frame is accepted, the engine reads address desc_base + descriptor offset + 4. frm_ready stays 0 from that cycle until the cycle after the second status write.
- R4: Three cycles after acceptance, the engine writes status word 0 at sts_base + status offset. The fields are: bit31 = 1, bit30 = 1 only if no error flag is set and the frame is not over-length, bit29 = 1, bit28 = 1, bit20 = overrun, bit19 = framing, bit18 = runt, bit17 = over-length, bit16 = CRC error, bit15 = CRC included. All other bits are 0.
- R5: In the next cycle, the engine writes status word 1 at that address + 4. The fields are: bit31 = 1, bits 30:16 = the buffer index taken from descriptor bits 30:16, bits 15:0 = the frame length.
- R6: A frame longer than the descriptor's buffer length (descriptor bits 15:0) sets bit17 and clears bit30 of status word 0.
- R7: After each status entry, each ring offset advances by 8 bytes. An offset returns to 0 when the next offset would reach or pass that ring's byte length. The two rings wrap independently.
- R8: A credit write adds its count to that ring's credit. Each completed entry takes one credit from each ring. A frame that arrives while either credit is 0 makes no memory access and raises drop_count by 1.
- R9: If irq_en is set when status word 1 is written, irq is high for exactly the following cycle. If irq_en is clear, irq stays 0.
- R10: A credit write in the same cycle as the completion of an entry takes full effect. The net change is the count written minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receive enable |
| irq_en | input | 1 | Receive interrupt enable |
| desc_base | input | AW | Descriptor ring base byte address |
| desc_ring_bytes | input | OW | Descriptor ring byte length |
| sts_base | input | AW | Status ring base byte address |
| sts_ring_bytes | input | OW | Status ring byte length |
| desc_enq_valid | input | 1 | Descriptor credit write strobe |
| desc_enq_num | input | clog2(RING_ENTRIES)+1 | Descriptor credits to add |
| sts_enq_valid | input | 1 | Status credit write strobe |
| sts_enq_num | input | clog2(RING_ENTRIES)+1 | Status credits to add |
| frm_valid | input | 1 | Frame-end pulse |
| frm_len | input | 16 | Received frame length in bytes |
| frm_overrun | input | 1 | FIFO overrun flag |
| frm_framing | input | 1 | Framing error flag |
| frm_runt | input | 1 | Runt frame flag |
| frm_crc_err | input | 1 | CRC error flag |
| frm_crc_incl | input | 1 | Length includes the CRC |
| frm_ready | output | 1 | Engine idle and able to take a frame |
| rx_active | output | 1 | Receive side running |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| irq | output | 1 | Receive interrupt pulse |
| drop_count | output | DCW | Frames dropped for lack of credit |

## Verification
The assertions assume the following about the inputs:
- frm_valid is a single-cycle pulse, raised only while frm_ready is high.
- Credit writes never push a ring's credit above RING_ENTRIES.
- Memory read data arrives one cycle after the read request.

The stimulus respects each of these:
- Frame pulses are issued only from the idle state, one cycle wide.
- The credit totals written stay at six or below.
- The bench memory registers its read data on the request edge.

Ring byte lengths are programmed to whole multiples of eight, so the wrap rule is exercised only on aligned offsets.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 16;
    localparam int IDX_W   = 15;
    localparam int IDX_LSB = 16;

    // status word 0 flag positions; software decodes these
    localparam int B_DONE = 31;
    localparam int B_OK   = 30;
    localparam int B_EOF  = 29;
    localparam int B_EOB  = 28;
    localparam int B_OVR  = 20;
    localparam int B_FRM  = 19;
    localparam int B_RUNT = 18;
    localparam int B_XTRA = 17;
    localparam int B_CRC  = 16;
    localparam int B_CRCI = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_STS0,
        ST_STS1
    } rxq_state_e;

    typedef struct packed {
        logic             overrun;
        logic             framing;
        logic             runt;
        logic             crc_err;
        logic             crc_incl;
        logic [LEN_W-1:0] len;
    } rxq_frame_t;

    function automatic logic [WORD_W-1:0] pack_sts0(rxq_frame_t f, logic over_len);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[B_DONE] = 1'b1;
        w[B_OK]   = ~(f.overrun | f.framing | f.runt | f.crc_err | over_len);
        w[B_EOF]  = 1'b1;
        w[B_EOB]  = 1'b1;
        w[B_OVR]  = f.overrun;
        w[B_FRM]  = f.framing;
        w[B_RUNT] = f.runt;
        w[B_XTRA] = over_len;
        w[B_CRC]  = f.crc_err;
        w[B_CRCI] = f.crc_incl;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_sts1(logic [IDX_W-1:0] idx, logic [LEN_W-1:0] len);
        return {1'b1, idx, len};
    endfunction

endpackage

// File: rtl/rxq_credit.sv
module rxq_credit #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_valid,
    input  logic [CW-1:0] add_num,
    input  logic          take,
    output logic [CW-1:0] cnt,
    output logic          nonzero
);

    logic [CW-1:0] cnt_q;

    // addition and consumption in the same cycle both land
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + (add_valid ? add_num : '0) - {{(CW-1){1'b0}}, take};
        end
    end

    assign cnt     = cnt_q;
    assign nonzero = (cnt_q != '0);

endmodule

// File: rtl/rxq_ring_ptr.sv
module rxq_ring_ptr #(
    parameter int OW   = 16,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] ring_bytes,
    input  logic          advance,
    output logic [OW-1:0] off
);

    logic [OW-1:0] off_q;
    logic [OW:0]   nxt;

    assign nxt = {1'b0, off_q} + (OW+1)'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (advance) begin
            if (nxt >= {1'b0, ring_bytes}) off_q <= '0;
            else                            off_q <= nxt[OW-1:0];
        end
    end

    assign off = off_q;

endmodule

// File: rtl/rxq_engine.sv
module rxq_engine
    import rxq_pkg::*;
#(
    parameter int AW           = 32,
    parameter int OW           = 16,
    parameter int RING_ENTRIES = 64,
    parameter int DCW          = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          irq_en,
    input  logic [AW-1:0]                 desc_base,
    input  logic [OW-1:0]                 desc_ring_bytes,
    input  logic [AW-1:0]                 sts_base,
    input  logic [OW-1:0]                 sts_ring_bytes,
    input  logic                          desc_enq_valid,
    input  logic [$clog2(RING_ENTRIES):0] desc_enq_num,
    input  logic                          sts_enq_valid,
    input  logic [$clog2(RING_ENTRIES):0] sts_enq_num,
    input  logic                          frm_valid,
    input  logic [15:0]                   frm_len,
    input  logic                          frm_overrun,
    input  logic                          frm_framing,
    input  logic                          frm_runt,
    input  logic                          frm_crc_err,
    input  logic                          frm_crc_incl,
    output logic                          frm_ready,
    output logic                          rx_active,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [AW-1:0]                 mem_addr,
    output logic [31:0]                   mem_wdata,
    input  logic [31:0]                   mem_rdata,
    output logic                          irq,
    output logic [DCW-1:0]                drop_count
);

    localparam int CW       = $clog2(RING_ENTRIES) + 1;
    localparam int ENT_STEP = 8;
    localparam int W1_OFS   = 4;

    rxq_state_e       state_q, state_d;
    rxq_frame_t       frm_q;
    logic [IDX_W-1:0] dsc_idx_q;
    logic [LEN_W-1:0] dsc_len_q;
    logic [CW-1:0]    desc_cred, sts_cred;
    logic             desc_nz, sts_nz;
    logic [OW-1:0]    desc_off, sts_off;
    logic             frame_seen, accept, drop, entry_done;
    logic             over_len;
    logic [AW-1:0]    desc_addr, sts_addr;
    logic             irq_q, active_q;
    logic [DCW-1:0]   drop_q;
    logic             rdata_unused;

    assign rdata_unused = mem_rdata[WORD_W-1];

    assign frame_seen = enable && frm_valid && (state_q == ST_IDLE);
    assign accept     = frame_seen && desc_nz && sts_nz;
    assign drop       = frame_seen && !(desc_nz && sts_nz);
    assign entry_done = (state_q == ST_STS1);

    rxq_credit #(.CW(CW)) u_desc_cred (
        .clk(clk), .rst_n(rst_n),
        .add_valid(desc_enq_valid), .add_num(desc_enq_num),
        .take(entry_done), .cnt(desc_cred), .nonzero(desc_nz)
    );

    rxq_credit #(.CW(CW)) u_sts_cred (
        .clk(clk), .rst_n(rst_n),
        .add_valid(sts_enq_valid), .add_num(sts_enq_num),
        .take(entry_done), .cnt(sts_cred), .nonzero(sts_nz)
    );

    rxq_ring_ptr #(.OW(OW), .STEP(ENT_STEP)) u_desc_ptr (
        .clk(clk), .rst_n(rst_n), .ring_bytes(desc_ring_bytes),
        .advance(entry_done), .off(desc_off)
    );

    rxq_ring_ptr #(.OW(OW), .STEP(ENT_STEP)) u_sts_ptr (
        .clk(clk), .rst_n(rst_n), .ring_bytes(sts_ring_bytes),
        .advance(entry_done), .off(sts_off)
    );

    assign desc_addr = desc_base + {{(AW-OW){1'b0}}, desc_off};
    assign sts_addr  = sts_base  + {{(AW-OW){1'b0}}, sts_off};
    assign over_len  = (frm_q.len > dsc_len_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_STS0;
            ST_STS0:  state_d = ST_STS1;
            ST_STS1:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // captured frame, descriptor fields, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q     <= '0;
            dsc_idx_q <= '0;
            dsc_len_q <= '0;
            irq_q     <= 1'b0;
            active_q  <= 1'b0;
            drop_q    <= '0;
        end else begin
            if (accept) begin
                frm_q.overrun  <= frm_overrun;
                frm_q.framing  <= frm_framing;
                frm_q.runt     <= frm_runt;
                frm_q.crc_err  <= frm_crc_err;
                frm_q.crc_incl <= frm_crc_incl;
                frm_q.len      <= frm_len;
            end
            if (state_q == ST_WAIT) begin
                dsc_idx_q <= mem_rdata[IDX_LSB +: IDX_W];
                dsc_len_q <= mem_rdata[LEN_W-1:0];
            end
            irq_q    <= entry_done && irq_en;
            active_q <= enable;
            if (drop) drop_q <= drop_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_FETCH: begin
                mem_en   = 1'b1;
                mem_addr = desc_addr + AW'(W1_OFS);
            end
            ST_STS0: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sts_addr;
                mem_wdata = pack_sts0(frm_q, over_len);
            end
            ST_STS1: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sts_addr + AW'(W1_OFS);
                mem_wdata = pack_sts1(dsc_idx_q, frm_q.len);
            end
            default: ;
        endcase
    end

    assign frm_ready  = (state_q == ST_IDLE);
    assign irq        = irq_q;
    assign rx_active  = active_q;
    assign drop_count = drop_q;

endmodule

// File: rtl/rxq_engine_chk.sv
module rxq_engine_chk #(
    parameter int RING_ENTRIES = 64,
    parameter int CW           = 7,
    parameter int DCW          = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic           frm_valid,
    input logic           frm_ready,
    input logic           rx_active,
    input logic           mem_en,
    input logic           mem_we,
    input logic [31:0]    mem_wdata,
    input logic           irq,
    input logic [DCW-1:0] drop_count,
    input logic [CW-1:0]  desc_cred,
    input logic [CW-1:0]  sts_cred
);

    p_active_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> rx_active);

    p_active_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable) |=> !rx_active);

    p_fetch_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frm_valid && frm_ready && desc_cred != '0 && sts_cred != '0)
        |=> (mem_en && !mem_we && !frm_ready));

    p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> mem_wdata[31]);

    p_write_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> (mem_en && mem_we));

    p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frm_valid && frm_ready && (desc_cred == '0 || sts_cred == '0))
        |=> (!mem_en && drop_count == DCW'($past(drop_count) + 1'b1)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(desc_cred) <= RING_ENTRIES) && (32'(sts_cred) <= RING_ENTRIES));

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_en && mem_we));

endmodule

bind rxq_engine rxq_engine_chk #(
    .RING_ENTRIES(RING_ENTRIES),
    .CW(CW),
    .DCW(DCW)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .enable(enable),
    .frm_valid(frm_valid),
    .frm_ready(frm_ready),
    .rx_active(rx_active),
    .mem_en(mem_en),
    .mem_we(mem_we),
    .mem_wdata(mem_wdata),
    .irq(irq),
    .drop_count(drop_count),
    .desc_cred(desc_cred),
    .sts_cred(sts_cred)
);

// File: tb/rxq_engine_tb.sv
`timescale 1ns/1ps
module rxq_engine_tb_top;

    localparam logic [31:0] DBASE  = 32'h100;
    localparam logic [31:0] SBASE  = 32'h400;
    localparam int          DBYTES = 32;
    localparam int          SBYTES = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, irq_en = 1'b0;
    logic        desc_enq_valid = 1'b0, sts_enq_valid = 1'b0;
    logic [6:0]  desc_enq_num = '0, sts_enq_num = '0;
    logic        frm_valid = 1'b0;
    logic [15:0] frm_len = '0;
    logic        frm_overrun = 0, frm_framing = 0, frm_runt = 0, frm_crc_err = 0, frm_crc_incl = 0;
    logic        frm_ready, rx_active, mem_en, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [15:0] drop_count;

    always #5 clk = ~clk;

    rxq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en),
        .desc_base(DBASE), .desc_ring_bytes(16'(DBYTES)),
        .sts_base(SBASE), .sts_ring_bytes(16'(SBYTES)),
        .desc_enq_valid(desc_enq_valid), .desc_enq_num(desc_enq_num),
        .sts_enq_valid(sts_enq_valid), .sts_enq_num(sts_enq_num),
        .frm_valid(frm_valid), .frm_len(frm_len), .frm_overrun(frm_overrun),
        .frm_framing(frm_framing), .frm_runt(frm_runt), .frm_crc_err(frm_crc_err),
        .frm_crc_incl(frm_crc_incl), .frm_ready(frm_ready), .rx_active(rx_active),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq), .drop_count(drop_count)
    );

    // behavioural memory, one-cycle read
    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
        if (mem_en && mem_we)  mem[mem_addr[11:2]] <= mem_wdata;
    end

    // reference model state
    int checks = 0, errors = 0;
    int dcred = 0, scred = 0, doff = 0, soff = 0, drops = 0;
    bit en_m = 0, irqen_m = 0, finished = 0, exp_active = 0;
    int d_idx [4] = '{5, 9, 12, 7};
    int d_len [4] = '{2048, 2048, 64, 2048};

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_w0(bit ov, bit fr, bit ru, bit ce, bit ci, bit ol);
        logic [31:0] w = '0;
        w[31] = 1'b1; w[30] = !(ov | fr | ru | ce | ol); w[29] = 1'b1; w[28] = 1'b1;
        w[20] = ov; w[19] = fr; w[18] = ru; w[17] = ol; w[16] = ce; w[15] = ci;
        return w;
    endfunction

    // clock-by-clock comparison of rx_active (R2)
    always @(posedge clk) exp_active <= rst_n ? enable : 1'b0;
    always @(negedge clk) if (rst_n && !finished) chk("R2", "rx_active", 32'(rx_active), 32'(exp_active));

    task automatic enq(int d, int s);
        @(negedge clk);
        desc_enq_valid = (d != 0); desc_enq_num = 7'(d);
        sts_enq_valid  = (s != 0); sts_enq_num  = 7'(s);
        dcred += d; scred += s;
        @(negedge clk);
        desc_enq_valid = 0; sts_enq_valid = 0;
    endtask

    task automatic send(int len, bit ov, bit fr, bit ru, bit ce, bit ci);
        bit acc;
        int de;
        bit ol;
        @(negedge clk);
        chk("R3", "frm_ready before frame", 32'(frm_ready), 32'd1);
        frm_len = 16'(len); frm_overrun = ov; frm_framing = fr; frm_runt = ru;
        frm_crc_err = ce; frm_crc_incl = ci; frm_valid = 1;
        acc = en_m && dcred > 0 && scred > 0;
        @(negedge clk);
        frm_valid = 0;
        if (!acc) begin
            if (en_m) drops++;
            chk("R8", "no access when refused", 32'(mem_en), 32'd0);
            chk("R8", "drop_count", 32'(drop_count), 32'(drops));
            return;
        end
        de = doff / 8;
        ol = (len > d_len[de]);
        chk("R3", "fetch strobe", {30'd0, mem_en, mem_we}, 32'b10);
        chk("R3", "fetch addr", mem_addr, DBASE + 32'(doff) + 32'd4);
        chk("R3", "busy", 32'(frm_ready), 32'd0);
        @(negedge clk);
        chk("R3", "wait quiet", 32'(mem_en), 32'd0);
        @(negedge clk);
        chk("R4", "w0 strobe", {30'd0, mem_en, mem_we}, 32'b11);
        chk("R7", "w0 addr", mem_addr, SBASE + 32'(soff));
        chk(ol ? "R6" : "R4", "w0 data", mem_wdata, exp_w0(ov, fr, ru, ce, ci, ol));
        @(negedge clk);
        chk("R5", "w1 strobe", {30'd0, mem_en, mem_we}, 32'b11);
        chk("R5", "w1 addr", mem_addr, SBASE + 32'(soff) + 32'd4);
        chk("R5", "w1 data", mem_wdata, {1'b1, 15'(d_idx[de]), 16'(len)});
        dcred--; scred--;
        doff = (doff + 8 >= DBYTES) ? 0 : doff + 8;
        soff = (soff + 8 >= SBYTES) ? 0 : soff + 8;
        @(negedge clk);
        chk("R9", "irq pulse", 32'(irq), 32'(irqen_m));
        chk("R3", "ready again", 32'(frm_ready), 32'd1);
        @(negedge clk);
        chk("R9", "irq single", 32'(irq), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++)
            mem[(DBASE >> 2) + 2 * i + 1] = {1'b0, 15'(d_idx[i]), 16'(d_len[i])};
        repeat (3) @(negedge clk);
        chk("R1", "frm_ready", 32'(frm_ready), 32'd1);
        chk("R1", "mem_en", 32'(mem_en), 32'd0);
        chk("R1", "irq", 32'(irq), 32'd0);
        chk("R1", "rx_active", 32'(rx_active), 32'd0);
        chk("R1", "drop_count", 32'(drop_count), 32'd0);
        rst_n = 1;
        @(negedge clk);
        // disabled: frame ignored (R2)
        send(100, 0, 0, 0, 0, 0);
        chk("R2", "no drop while disabled", 32'(drop_count), 32'd0);
        enable = 1; en_m = 1; irq_en = 1; irqen_m = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "active after enable", 32'(rx_active), 32'd1);
        send(64, 0, 0, 0, 0, 0);          // R8 both rings empty
        enq(6, 0);
        send(64, 0, 0, 0, 0, 0);          // R8 status ring empty
        enq(0, 6);
        send(60, 0, 0, 0, 0, 1);          // R4 clean frame
        send(1500, 1, 0, 1, 0, 0);        // R4 overrun + runt
        send(100, 0, 0, 0, 0, 0);         // R6 over-length on entry 2
        send(2044, 0, 1, 0, 1, 1);        // R4 framing + crc, R7 status wrap
        send(64, 0, 0, 0, 0, 0);          // R7 descriptor wrap
        irq_en = 0; irqen_m = 0;
        send(80, 0, 0, 0, 0, 0);          // R9 masked
        irq_en = 1; irqen_m = 1;
        // R10 credit write coincides with completion
        enq(1, 1);
        fork
            send(90, 0, 0, 0, 1, 0);
            begin repeat (4) @(negedge clk); enq(1, 1); end
        join
        send(70, 0, 0, 0, 0, 0);          // R10 accepted on the added credit
        send(70, 0, 0, 0, 0, 0);          // R10 then refused
        chk("R10", "final drops", 32'(drop_count), 32'd3);
        enable = 0; en_m = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "inactive after disable", 32'(rx_active), 32'd0);
        send(64, 0, 0, 0, 0, 0);
        chk("R2", "ignored when disabled", 32'(drop_count), 32'd3);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule